// File: doc/BRIEF.md
# Keyboard Matrix Scanner with Key-Code Queue

This block walks a key matrix one row at a time on four scan outputs and reads back eight column lines. A programmable divider turns the system clock into a slower scan tick, and each tick moves the scan to the next row. The scan outputs can carry a plain binary row count, which an external decoder fans out to 16 lines. They can also carry a one-of-four active-low pattern that drives four rows directly.

A closed key is accepted only after a hold period: the key must still read closed when its row comes round again after that period. An accepted key is packed with the state of the shift and control inputs into one byte. That byte goes into an eight-entry first-in first-out queue. The host reads that queue, or a status byte, through a chip-select, read and write strobe interface with a one-bit address. An interrupt line stays high while the queue is not empty.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: After reset the block is in binary scan mode. In that mode `scanOut` is an active-high count that starts at 0000 after reset and steps by one per scan tick up to 1111, then wraps to 0000. Only counts 0 to 7 address key rows (row = count bits 2:0).
- R2: In one-hot mode `scanOut` cycles 1110, 1101, 1011, 0111 and then back to 1110, with the low bit of the pattern standing for row 0. Those four rows are the only key rows in this mode.
- R3: A host write with `a0` high loads a command byte. Bit 7 selects one-hot mode (1) or binary mode (0). Bits 5:0 give the divider N: each scan step lasts N clocks, and N of 0 or 1 means one clock. The write restarts the scan at its first step. After reset N is `RESET_DIV`.
- R4: A closed key reads as 0 on `retN`. A detected key is accepted only if it still reads closed the first time its row is scanned after `HOLD_TICKS` further scan ticks. Otherwise it is discarded.
- R5: An accepted key yields exactly one code however long it is held. No new key is looked for until that key is seen open on its row.
- R6: Key code layout: bit 7 = `ctrlKey`, bit 6 = `shiftKey` (both taken at acceptance), bits 5:3 = row, bits 2:0 = the lowest-numbered closed column in that row.
- R7: Codes leave in order of acceptance, up to eight held. A data read (`csN`=0, `rdN`=0, `a0`=0) presents the oldest code on `rdData` and removes it at the clock edge. A data read of an empty queue returns 00 and changes nothing.
- R8: `irq` is high exactly when the queue holds at least one code.
- R9: Status byte, read with `a0` high: bits 3:0 = number of codes held, bit 6 = full, bit 7 = overrun. A key accepted while the queue is full is dropped and sets overrun. A status read clears overrun, except that a drop in the same cycle leaves it set.
- R10: With `csN` high, reads and writes have no effect and `rdData` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low, one clock per access |
| wrN | input | 1 | Write strobe, active low, one clock per access |
| a0 | input | 1 | 0 selects key data, 1 selects status or command |
| wrData | input | 8 | Command byte |
| rdData | output | 8 | Key code or status byte; 00 when no read |
| retN | input | 8 | Column return lines, low = closed |
| shiftKey | input | 1 | Shift modifier level |
| ctrlKey | input | 1 | Control modifier level |
| scanOut | output | 4 | Row scan lines |
| irq | output | 1 | High while the queue is not empty |

## Verification
The two functions that can meet in one cycle are the overrun flag being set by a dropped key and the same flag being cleared by a status read. To provoke the collision, the queue is first filled with eight keys and a ninth key is then held down. Throughout the acceptance window the host keeps the status read strobe asserted on every clock, so whichever cycle the drop lands in, a clear is requested in that same cycle. The run is judged correct only if overrun is observed set on the status byte at least once during that window, and is seen cleared, with the count still eight, once the reads stop.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  localparam int CODE_W = 8;

  typedef struct packed {
    logic              push;
    logic [CODE_W-1:0] code;
    logic              popData;
    logic              readStat;
  } kbdStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_WAIT_REL
  } keyState_t;
endpackage

// File: rtl/kbd_scan_ctrl.sv
module kbd_scan_ctrl
  import kbd_scan_pkg::*;
#(
  parameter int DIV_W      = 6,
  parameter int RESET_DIV  = 5,
  parameter int HOLD_TICKS = 24,
  parameter int COLS       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic             a0,
  input  logic [7:0]       wrData,
  input  logic [COLS-1:0]  retN,
  input  logic             shiftKey,
  input  logic             ctrlKey,
  output logic [3:0]       scanOut,
  output kbdStrobe_t       strobe
);
  localparam int MODE_BIT = 7;
  localparam int HOLD_W   = $clog2(HOLD_TICKS + 1);
  localparam int COL_W    = $clog2(COLS);

  logic             readAcc, writeCmd, tick;
  logic [DIV_W-1:0] divN, preCnt;
  logic             decMode;
  logic [3:0]       scanCnt;
  logic             rowValid;
  logic [2:0]       curRow;
  logic [COLS-1:0]  closed;
  logic             anyClosed;
  logic [COL_W-1:0] lowCol;

  keyState_t        state;
  logic [2:0]       candRow;
  logic [COL_W-1:0] candCol;
  logic [HOLD_W-1:0] holdCnt;
  logic             holdDone, rowHit, pushNow;

  // host access decode
  assign readAcc  = !csN && !rdN;
  assign writeCmd = !csN && !wrN && a0;

  // scan timebase
  assign tick = (divN <= DIV_W'(1)) || (preCnt >= divN - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divN    <= DIV_W'(RESET_DIV);
      decMode <= 1'b0;
      preCnt  <= '0;
      scanCnt <= '0;
    end else if (writeCmd) begin
      divN    <= wrData[DIV_W-1:0];
      decMode <= wrData[MODE_BIT];
      preCnt  <= '0;
      scanCnt <= '0;
    end else if (tick) begin
      preCnt  <= '0;
      scanCnt <= (decMode && scanCnt == 4'd3) ? 4'd0 : scanCnt + 4'd1;
    end else begin
      preCnt  <= preCnt + DIV_W'(1);
    end
  end

  assign scanOut  = decMode ? ~(4'b0001 << scanCnt[1:0]) : scanCnt;
  assign rowValid = decMode ? 1'b1 : !scanCnt[3];
  assign curRow   = decMode ? {1'b0, scanCnt[1:0]} : scanCnt[2:0];

  // column pick: lowest closed column wins
  assign closed    = ~retN;
  assign anyClosed = |closed;
  always_comb begin
    lowCol = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (closed[i]) lowCol = COL_W'(i);
    end
  end

  // debounce sequencing
  assign holdDone = (holdCnt >= HOLD_W'(HOLD_TICKS));
  assign rowHit   = rowValid && (curRow == candRow);
  assign pushNow  = tick && !writeCmd && (state == ST_HOLD) && holdDone &&
                    rowHit && closed[candCol];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      candRow <= '0;
      candCol <= '0;
      holdCnt <= '0;
    end else if (writeCmd) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (rowValid && anyClosed) begin
            candRow <= curRow;
            candCol <= lowCol;
            holdCnt <= '0;
            state   <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (!holdDone) begin
            holdCnt <= holdCnt + HOLD_W'(1);
          end else if (rowHit) begin
            state <= closed[candCol] ? ST_WAIT_REL : ST_IDLE;
          end
        end
        ST_WAIT_REL: begin
          if (rowHit && !closed[candCol]) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.push     = pushNow;
    strobe.code     = {ctrlKey, shiftKey, candRow, candCol};
    strobe.popData  = readAcc && !a0;
    strobe.readStat = readAcc && a0;
  end

  // scan lines only move on a tick or a command
  assert_scan_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !writeCmd) |=> $stable(scanOut));

  // one-hot mode drives exactly one low line
  assert_onehot_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    decMode |-> ($countones(~scanOut) == 1));

  // no second code while the accepted key is still held
  assert_single_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_REL) |-> !strobe.push);

  // a code is only produced after a completed hold window
  assert_hold_before_push_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> (state == ST_WAIT_REL));
endmodule

// File: rtl/kbd_fifo_dp.sv
module kbd_fifo_dp
  import kbd_scan_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  kbdStrobe_t        strobe,
  output logic [CODE_W-1:0] rdData,
  output logic              irq
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CODE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              overrun;
  logic              empty, full, doPop, doPush, dropped;
  logic [CODE_W-1:0] headCode, statusByte;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign doPop   = strobe.popData && !empty;
  assign doPush  = strobe.push && (!full || doPop);
  assign dropped = strobe.push && !doPush;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= strobe.code;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
      if (dropped)              overrun <= 1'b1;
      else if (strobe.readStat) overrun <= 1'b0;
    end
  end

  assign headCode = empty ? '0 : mem[rdPtr];

  always_comb begin
    statusByte            = '0;
    statusByte[7]         = overrun;
    statusByte[6]         = full;
    statusByte[CNT_W-1:0] = count;
  end

  assign rdData = strobe.popData  ? headCode :
                  strobe.readStat ? statusByte : '0;
  assign irq    = !empty;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  assert_push_grows_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !full && !strobe.popData) |=> (count == $past(count) + CNT_W'(1)));

  assert_drop_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && full && !strobe.popData) |=> overrun);

  assert_status_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.readStat && !strobe.push) |=> !overrun);

  assert_irq_tracks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !full) |=> irq);
endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner
  import kbd_scan_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int DIV_W      = 6,
  parameter int RESET_DIV  = 5,
  parameter int HOLD_TICKS = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       a0,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [7:0] retN,
  input  logic       shiftKey,
  input  logic       ctrlKey,
  output logic [3:0] scanOut,
  output logic       irq
);
  kbdStrobe_t strobe;

  kbd_scan_ctrl #(
    .DIV_W(DIV_W), .RESET_DIV(RESET_DIV), .HOLD_TICKS(HOLD_TICKS), .COLS(8)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .a0(a0),
    .wrData(wrData), .retN(retN), .shiftKey(shiftKey), .ctrlKey(ctrlKey),
    .scanOut(scanOut), .strobe(strobe)
  );

  kbd_fifo_dp #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/kbd_matrix_scanner_tb.sv
module kbd_matrix_scanner_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1, a0 = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] retN;
  logic       shiftKey = 1'b0, ctrlKey = 1'b0;
  logic [3:0] scanOut;
  logic       irq;

  logic [7:0] keyMask [8];
  logic       benchDec = 1'b0;
  int         nChecks = 0, nFail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  kbd_matrix_scanner dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .a0(a0),
    .wrData(wrData), .rdData(rdData), .retN(retN), .shiftKey(shiftKey),
    .ctrlKey(ctrlKey), .scanOut(scanOut), .irq(irq)
  );

  // key matrix model
  always_comb begin
    retN = 8'hFF;
    if (!benchDec) begin
      if (!scanOut[3]) retN = ~keyMask[scanOut[2:0]];
    end else begin
      case (scanOut)
        4'b1110: retN = ~keyMask[0];
        4'b1101: retN = ~keyMask[1];
        4'b1011: retN = ~keyMask[2];
        4'b0111: retN = ~keyMask[3];
        default: retN = 8'hFF;
      endcase
    end
  end

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic host_read(input logic addr, output logic [7:0] val);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; a0 = addr;
    #1 val = rdData;
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic host_write(input logic [7:0] val);
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; a0 = 1'b1; wrData = val;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic measure_step(output int len);
    logic [3:0] prev;
    @(negedge clk);
    prev = scanOut;
    while (scanOut == prev) @(negedge clk);
    prev = scanOut;
    len = 0;
    while (scanOut == prev) begin
      @(negedge clk);
      len++;
    end
  endtask

  task automatic wait_count(input int target);
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      host_read(1'b1, s);
      if (int'(s[3:0]) == target) return;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic release_all();
    for (int r = 0; r < 8; r++) keyMask[r] = 8'h00;
    repeat (300) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [7:0] v;
    @(negedge clk);
    check("R1", "scan after reset", {4'h0, scanOut}, 8'h00);
    check("R8", "irq after reset", {7'h0, irq}, 8'h00);
    host_read(1'b1, v);
    check("R9", "status after reset", v, 8'h00);
    host_read(1'b0, v);
    check("R7", "empty data read", v, 8'h00);
  endtask

  task automatic test_prescale();
    int len;
    logic [3:0] prev;
    bit seqOk;
    host_write(8'h03);
    check("R3", "scan restarts on command", {4'h0, scanOut}, 8'h00);
    measure_step(len);
    check("R3", "step length N=3", 8'(len), 8'd3);
    seqOk = 1'b1;
    prev = scanOut;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      while (scanOut == prev) @(negedge clk);
      if (scanOut != prev + 4'd1) seqOk = 1'b0;
      prev = scanOut;
    end
    check("R1", "binary count steps and wraps", {7'h0, seqOk}, 8'h01);
    host_write(8'h01);
    measure_step(len);
    check("R3", "step length N=1", 8'(len), 8'd1);
    host_write(8'h05);
  endtask

  task automatic test_decoded();
    logic [3:0] prev;
    logic [7:0] v;
    host_write(8'h85);
    benchDec = 1'b1;
    check("R2", "first one-hot step", {4'h0, scanOut}, 8'h0E);
    prev = scanOut;
    for (int i = 0; i < 4; i++) begin
      while (scanOut == prev) @(negedge clk);
      prev = scanOut;
      check("R2", "one-hot sequence", {4'h0, scanOut},
            (i == 3) ? 8'h0E : {4'h0, ~(4'b0010 << i)});
    end
    shiftKey = 1'b1;
    keyMask[2] = 8'b0010_0000;
    wait_count(1);
    shiftKey = 1'b0;
    host_read(1'b0, v);
    check("R6", "one-hot row 2 col 5 shift", v, 8'h55);
    release_all();
    host_write(8'h05);
    benchDec = 1'b0;
  endtask

  task automatic test_key_encoded();
    logic [7:0] v;
    ctrlKey = 1'b1;
    keyMask[6] = 8'b0000_1010;
    for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
    check("R8", "irq on first code", {7'h0, irq}, 8'h01);
    ctrlKey = 1'b0;
    repeat (400) @(negedge clk);
    host_read(1'b1, v);
    check("R5", "held key gives one code", v, 8'h01);
    host_read(1'b0, v);
    check("R6", "row 6 lowest col 1 ctrl", v, 8'hB1);
    @(negedge clk);
    check("R8", "irq drops when empty", {7'h0, irq}, 8'h00);
    release_all();
  endtask

  task automatic test_short_press();
    logic [7:0] v;
    keyMask[4] = 8'h04;
    repeat (80) @(negedge clk);
    keyMask[4] = 8'h00;
    repeat (500) @(negedge clk);
    host_read(1'b1, v);
    check("R4", "short press discarded", v, 8'h00);
  endtask

  task automatic test_chip_select();
    logic [7:0] v;
    int len;
    @(negedge clk);
    wrN = 1'b0; a0 = 1'b1; wrData = 8'h82;
    @(negedge clk);
    wrN = 1'b1;
    measure_step(len);
    check("R10", "deselected write ignored", 8'(len), 8'd5);
    keyMask[3] = 8'h80;
    wait_count(1);
    release_all();
    @(negedge clk);
    rdN = 1'b0; a0 = 1'b0;
    #1 v = rdData;
    @(negedge clk);
    rdN = 1'b1;
    check("R10", "deselected read data", v, 8'h00);
    host_read(1'b1, v);
    check("R10", "deselected read no pop", v, 8'h01);
    host_read(1'b0, v);
    check("R6", "row 3 col 7", v, 8'h1F);
  endtask

  task automatic test_fifo_overrun();
    logic [7:0] v;
    bit seenOvr;
    for (int i = 0; i < 8; i++) begin
      keyMask[i] = 8'(1 << (7 - i));
      wait_count(i + 1);
      release_all();
    end
    host_read(1'b1, v);
    check("R9", "full status", v, 8'h48);
    keyMask[7] = 8'h80;
    seenOvr = 1'b0;
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; a0 = 1'b1;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (rdData[7]) seenOvr = 1'b1;
    end
    csN = 1'b1; rdN = 1'b1;
    check("R9", "overrun set despite concurrent status read", {7'h0, seenOvr}, 8'h01);
    release_all();
    host_read(1'b1, v);
    check("R9", "overrun cleared, count kept", v, 8'h48);
    for (int i = 0; i < 8; i++) begin
      host_read(1'b0, v);
      check("R7", "queue order", v, {2'b00, 3'(i), 3'(7 - i)});
    end
    host_read(1'b1, v);
    check("R7", "empty after drain", v, 8'h00);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) keyMask[r] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_prescale();
    test_decoded();
    test_key_encoded();
    test_short_press();
    test_chip_select();
    test_fifo_overrun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule